// File: doc/BRIEF.md
# BCD Watchdog Timer with Interrupt/Reset Steering

This block is a host-programmable watchdog that counts down in binary-coded decimal. The host loads a four-digit timeout in hundredths of a second, from 0.01 s up to 99.99 s, into two byte registers. A 100 Hz enable input (`tick`) paces the count, so each tick is one 10 ms step. Any write to either timeout byte restarts the count from the programmed value. The counter also reloads by itself every time it expires. Writing zero to both bytes stops the watchdog.

Every expiry sets a sticky watchdog flag, whether or not the watchdog is enabled. Two control bits decide what else happens:

- With the enable bit clear, the flag is the only effect.
- In repetitive mode (enable set, steer clear), the interrupt output follows the flag.
- In single-shot mode (enable set, steer set), expiry starts a reset pulse of a fixed number of ticks. When that pulse ends, the block clears its own enable bit.

Reset forces both control bits, the flag and both timeout bytes to zero.

The host writes through a one-cycle write strobe with a two-bit address:

| Address | Register | Contents |
|---|---|---|
| 0 | fraction byte | tenths digit in bits 7:4, hundredths digit in bits 3:0 |
| 1 | seconds byte | tens digit in bits 7:4, units digit in bits 3:0 |
| 2 | control | bit 0 is enable, bit 1 is steer |
| 3 | flag | writing bit 0 = 0 clears the flag; writing a 1 does nothing |

The controller has three states, each named below with its transitions:

- **IDLE**: the timeout bytes are both zero. IDLE to COUNT on a timeout write that leaves a nonzero value.
- **COUNT**: counting. COUNT to IDLE on a write that leaves both bytes zero. COUNT to PULSE on an expiry while enable and steer are both set.
- **PULSE**: the reset output is high, and counting continues. PULSE to COUNT when the pulse ends and the bytes are nonzero. PULSE to IDLE when the pulse ends and the bytes are zero.

Top module: `bcd_watchdog`

## Requirements
- R1: After reset, `wd_flag`, `wd_irq`, `wd_reset`, `wd_enable` and `wd_steer` are all 0, and the watchdog is stopped.
- R2: With a nonzero value N (the four BCD digits read as a decimal number of ticks), `wd_flag` rises on the Nth tick after the last timeout-byte write and not before. Borrows across all four digits work, up to N = 9999.
- R3: After an expiry, the counter reloads N, and the next expiry comes N ticks later.
- R4: A write to either timeout byte restarts the count from the full programmed value.
- R5: While both timeout bytes are zero, ticks never set the flag.
- R6: An expiry sets `wd_flag` whatever the enable bit is. With enable = 0, `wd_irq` and `wd_reset` stay 0.
- R7: In repetitive mode (enable = 1, steer = 0), `wd_irq` is high exactly while the flag is set, and `wd_reset` stays 0.
- R8: In single-shot mode (enable = 1, steer = 1), an expiry raises `wd_reset` for exactly PULSE_TICKS ticks. When the pulse ends, `wd_enable` reads 0 and `wd_steer` keeps its value.
- R9: Writing address 3 with bit 0 = 0 clears the flag. Writing it with bit 0 = 1 leaves the flag unchanged.
- R10: A timeout-byte write in the same cycle as an expiring tick reloads the counter and suppresses that expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | 100 Hz count enable, one cycle wide |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 2 | Write address: 0 fraction, 1 seconds, 2 control, 3 flag |
| wr_data | input | 8 | Write data |
| wd_flag | output | 1 | Sticky watchdog flag |
| wd_irq | output | 1 | Interrupt request, used in repetitive mode |
| wd_reset | output | 1 | Reset pulse, used in single-shot mode |
| wd_enable | output | 1 | Current enable bit |
| wd_steer | output | 1 | Current steer bit |

## Verification
The bench builds the block with PULSE_TICKS = 3. This keeps a full single-shot pulse, and its self-clearing enable, within a few ticks of the expiry. Tick is driven every cycle for the largest value, 99.99 s. The 9999-step count, with its borrow through every digit, then fits in about ten thousand cycles. Small values such as 3, 5, 10 and 100 aim at the units, tenths and seconds borrows, the reload and the same-cycle collision of a write with an expiry.

// File: rtl/bcd_wd_pkg.sv
package bcd_wd_pkg;
    localparam int WD_DIGITS = 4;
    localparam int WD_VAL_W  = WD_DIGITS * 4;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_COUNT,
        ST_PULSE
    } wd_state_e;

    typedef enum logic [1:0] {
        AD_FRAC = 2'd0,
        AD_SECS = 2'd1,
        AD_CTRL = 2'd2,
        AD_FLAG = 2'd3
    } wd_addr_e;
endpackage

// File: rtl/bcd_wd_counter.sv
module bcd_wd_counter #(
    parameter int DIGITS = 4,
    localparam int W = DIGITS * 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         armed,
    input  logic         load,
    input  logic [W-1:0] ld_val,
    output logic         timeout
);
    logic [W-1:0]    cnt;
    logic [W-1:0]    dec;
    logic [DIGITS:0] borrow;
    logic            is_one;

    assign borrow[0] = 1'b1;

    // BCD decrement, one digit per stage, borrow rippling upward
    for (genvar i = 0; i < DIGITS; i++) begin : g_dig
        logic [3:0] d;
        assign d = cnt[i*4 +: 4];
        always_comb begin
            if (!borrow[i]) begin
                dec[i*4 +: 4] = d;
                borrow[i+1]   = 1'b0;
            end else if (d == 4'd0) begin
                dec[i*4 +: 4] = 4'd9;
                borrow[i+1]   = 1'b1;
            end else begin
                dec[i*4 +: 4] = d - 4'd1;
                borrow[i+1]   = 1'b0;
            end
        end
    end

    assign is_one  = (cnt == W'(1));
    assign timeout = tick && armed && !load && is_one;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= ld_val;
        end else if (tick && armed) begin
            cnt <= is_one ? ld_val : dec;
        end
    end

    // R3: expiry reloads the programmed value
    p_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |=> (cnt == $past(ld_val)));

    // R2: every counted tick moves the count
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && armed && !load && !timeout) |=> (cnt != $past(cnt)));
endmodule

// File: rtl/bcd_wd_pulse.sv
module bcd_wd_pulse #(
    parameter int TICKS = 10,
    localparam int PW = $clog2(TICKS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic start,
    output logic active,
    output logic done
);
    logic [PW-1:0] pcnt;

    assign active = (pcnt != '0);
    assign done   = active && tick && (pcnt == PW'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pcnt <= '0;
        end else if (start) begin
            pcnt <= PW'(TICKS);
        end else if (active && tick) begin
            pcnt <= pcnt - PW'(1);
        end
    end

    // R8: pulse length never exceeds the configured tick count
    p_pulse_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pcnt <= PW'(TICKS));
endmodule

// File: rtl/bcd_watchdog.sv
module bcd_watchdog
    import bcd_wd_pkg::*;
#(
    parameter int PULSE_TICKS = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       wr_en,
    input  logic [1:0] wr_addr,
    input  logic [7:0] wr_data,
    output logic       wd_flag,
    output logic       wd_irq,
    output logic       wd_reset,
    output logic       wd_enable,
    output logic       wd_steer
);
    wd_state_e state, state_n;

    logic [7:0] frac_q, secs_q, frac_n, secs_n;
    logic       en_q, steer_q, flag_q;
    logic       wr_frac, wr_secs, wr_ctrl, wr_flag;
    logic       load, armed_q, armed_n;
    logic       tmo, pulse_start, pulse_active, pulse_done;

    assign wr_frac = wr_en && (wr_addr == AD_FRAC);
    assign wr_secs = wr_en && (wr_addr == AD_SECS);
    assign wr_ctrl = wr_en && (wr_addr == AD_CTRL);
    assign wr_flag = wr_en && (wr_addr == AD_FLAG);

    assign frac_n  = wr_frac ? wr_data : frac_q;
    assign secs_n  = wr_secs ? wr_data : secs_q;
    assign load    = wr_frac || wr_secs;
    assign armed_q = |{secs_q, frac_q};
    assign armed_n = |{secs_n, frac_n};

    bcd_wd_counter #(.DIGITS(WD_DIGITS)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .armed   (armed_q),
        .load    (load),
        .ld_val  ({secs_n, frac_n}),
        .timeout (tmo)
    );

    assign pulse_start = tmo && en_q && steer_q && (state != ST_PULSE);

    bcd_wd_pulse #(.TICKS(PULSE_TICKS)) u_pulse (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .start  (pulse_start),
        .active (pulse_active),
        .done   (pulse_done)
    );

    // register file
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frac_q  <= '0;
            secs_q  <= '0;
            en_q    <= 1'b0;
            steer_q <= 1'b0;
            flag_q  <= 1'b0;
        end else begin
            frac_q <= frac_n;
            secs_q <= secs_n;
            if (pulse_done)   en_q <= 1'b0;
            else if (wr_ctrl) en_q <= wr_data[0];
            if (wr_ctrl)      steer_q <= wr_data[1];
            if (tmo)                          flag_q <= 1'b1;
            else if (wr_flag && !wr_data[0])  flag_q <= 1'b0;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // next state
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:  if (load && armed_n) state_n = ST_COUNT;
            ST_COUNT: begin
                if (load && !armed_n) state_n = ST_IDLE;
                else if (pulse_start) state_n = ST_PULSE;
            end
            ST_PULSE: if (pulse_done) state_n = armed_n ? ST_COUNT : ST_IDLE;
            default:  state_n = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        wd_flag   = flag_q;
        wd_enable = en_q;
        wd_steer  = steer_q;
        wd_irq    = flag_q && en_q && !steer_q;
        wd_reset  = (state == ST_PULSE);
    end

    // R6: the flag only rises after an expiry
    p_flag_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(tmo));

    // R8: the state machine and the pulse timer agree
    p_pulse_sync_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PULSE) == pulse_active);

    // R8: end of pulse leaves the watchdog disabled
    p_end_clears_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wd_reset) |-> !en_q);

    // R5: a stopped watchdog cannot raise the flag
    p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |=> !$rose(flag_q));
endmodule

// File: tb/tb_bcd_watchdog.sv
module tb_bcd_watchdog;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic wd_flag, wd_irq, wd_reset, wd_enable, wd_steer;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    bcd_watchdog #(.PULSE_TICKS(3)) dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .wd_flag(wd_flag),
        .wd_irq(wd_irq), .wd_reset(wd_reset), .wd_enable(wd_enable),
        .wd_steer(wd_steer)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic t_reset();
        check("R1 flag", 16'(wd_flag), 0);
        check("R1 irq", 16'(wd_irq), 0);
        check("R1 reset", 16'(wd_reset), 0);
        check("R1 enable", 16'(wd_enable), 0);
        check("R1 steer", 16'(wd_steer), 0);
        ticks(20);
        check("R1 stopped", 16'(wd_flag), 0);
    endtask

    task automatic t_period_flag();
        wr(2'd0, 8'h05); wr(2'd1, 8'h00);
        ticks(4);
        check("R2 early", 16'(wd_flag), 0);
        ticks(1);
        check("R2 on time", 16'(wd_flag), 1);
        check("R6 irq low", 16'(wd_irq), 0);
        check("R6 reset low", 16'(wd_reset), 0);
        wr(2'd3, 8'h01);
        check("R9 write one ignored", 16'(wd_flag), 1);
        wr(2'd3, 8'h00);
        check("R9 cleared", 16'(wd_flag), 0);
        ticks(4);
        check("R3 reload early", 16'(wd_flag), 0);
        ticks(1);
        check("R3 reload period", 16'(wd_flag), 1);
        wr(2'd3, 8'h00);
    endtask

    task automatic t_borrow();
        wr(2'd0, 8'h10);
        ticks(9);
        check("R2 tenths borrow early", 16'(wd_flag), 0);
        ticks(1);
        check("R2 tenths borrow", 16'(wd_flag), 1);
        wr(2'd3, 8'h00);
        wr(2'd0, 8'h00); wr(2'd1, 8'h01);
        ticks(99);
        check("R2 seconds borrow early", 16'(wd_flag), 0);
        ticks(1);
        check("R2 seconds borrow", 16'(wd_flag), 1);
        wr(2'd3, 8'h00);
    endtask

    task automatic t_restart();
        wr(2'd1, 8'h00); wr(2'd0, 8'h05);
        ticks(3);
        wr(2'd1, 8'h00);
        ticks(4);
        check("R4 restarted", 16'(wd_flag), 0);
        ticks(1);
        check("R4 full period", 16'(wd_flag), 1);
        wr(2'd3, 8'h00);
    endtask

    task automatic t_zero();
        wr(2'd0, 8'h00); wr(2'd1, 8'h00);
        ticks(150);
        check("R5 stopped", 16'(wd_flag), 0);
    endtask

    task automatic t_repeat();
        wr(2'd2, 8'h01);
        wr(2'd0, 8'h03);
        ticks(3);
        check("R7 flag", 16'(wd_flag), 1);
        check("R7 irq", 16'(wd_irq), 1);
        check("R7 no reset", 16'(wd_reset), 0);
        wr(2'd3, 8'h00);
        check("R7 irq clears", 16'(wd_irq), 0);
        check("R7 enable kept", 16'(wd_enable), 1);
    endtask

    task automatic t_single();
        wr(2'd2, 8'h03);
        wr(2'd0, 8'h04);
        ticks(4);
        check("R8 reset up", 16'(wd_reset), 1);
        check("R8 irq low", 16'(wd_irq), 0);
        check("R6 flag in single", 16'(wd_flag), 1);
        ticks(2);
        check("R8 reset held", 16'(wd_reset), 1);
        ticks(1);
        check("R8 reset ends", 16'(wd_reset), 0);
        check("R8 enable cleared", 16'(wd_enable), 0);
        check("R8 steer kept", 16'(wd_steer), 1);
        wr(2'd2, 8'h00);
        wr(2'd3, 8'h00);
    endtask

    task automatic t_collide();
        wr(2'd0, 8'h03);
        ticks(2);
        @(negedge clk);
        tick = 1'b1; wr_en = 1'b1; wr_addr = 2'd0; wr_data = 8'h03;
        @(negedge clk);
        tick = 1'b0; wr_en = 1'b0;
        check("R10 expiry dropped", 16'(wd_flag), 0);
        ticks(2);
        check("R10 reloaded early", 16'(wd_flag), 0);
        ticks(1);
        check("R10 reloaded period", 16'(wd_flag), 1);
        wr(2'd3, 8'h00);
    endtask

    task automatic t_max();
        wr(2'd0, 8'h99); wr(2'd1, 8'h99);
        @(negedge clk); tick = 1'b1;
        repeat (9998) @(negedge clk);
        check("R2 max early", 16'(wd_flag), 0);
        @(negedge clk);
        check("R2 max 9999", 16'(wd_flag), 1);
        tick = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_period_flag();
        t_borrow();
        t_restart();
        t_zero();
        t_repeat();
        t_single();
        t_collide();
        t_max();
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule